// File: doc/BRIEF.md
# Clocked Serial Character Transmitter with Synchronous Capture

This block sends one character as an asynchronous frame on `txd`: a low start bit, the data bits with the least significant bit first, and a high stop bit. Each part takes one bit time. While the data bits are on the line, the block also drives a serial clock on `sclk`, so that a synchronous slave can shift the bits in. Data returned by the slave on `rxd` is sampled once in each clocked data bit, and the bits are assembled into a received word.

Timing comes from two single-cycle strobes supplied by the surrounding logic. `bit_tick` marks each bit boundary. `os_tick` is the oversampling strobe, with `OS_RATE` pulses in each bit time. A frame is requested with `load` while the block is idle, and the frame begins at the next `bit_tick`. The width, clock idle level, clock phase and last-pulse setting are taken at that moment and held for the whole frame. At the end of the stop bit, the received word is presented and `rx_done` pulses.

Top module: `usart_sync_tx`

## Requirements
- R1: After reset, `txd` is 1, `rx_done` is 0 and `rx_word` is 0. When idle, `txd` stays 1 and, from the first clock after reset, `sclk` follows the `cpol` input.
- R2: A `load` taken while idle starts a frame at the next `bit_tick`. The start bit (0), each data bit and the stop bit (1) each last one bit time, so `rx_done` rises exactly (N+2) bit times after the start bit falls.
- R3: With `nine_bit`=1 the frame carries `data_in[8:0]`; with `nine_bit`=0 it carries `data_in[7:0]`, and `data_in[8]` is never sent. Bits go out bit 0 first.
- R4: During the start bit and the stop bit, `sclk` makes no transition and rests at the idle level `cpol`.
- R5: Each clocked data bit gets one pulse, and `rxd` is sampled at mid-bit (the OS_RATE/2-th oversampling strobe after the boundary). With `cpha`=0, `sclk` leaves its idle level at mid-bit, so sampling is on the leading edge, and it returns at the end of the bit. With `cpha`=1, `sclk` leaves at the start of the bit and returns at mid-bit, so sampling is on the trailing edge.
- R6: With `last_pulse_en`=1 every data bit is clocked, which gives 2N `sclk` transitions per frame. With 0, the last data bit gets no pulse, which gives 2(N-1).
- R7: `rx_word` holds the sampled bits, with bit k taken in data bit k. Bits not sampled (the last bit when its pulse is off, and bit 8 in 8-bit frames) read 0.
- R8: `rx_done` is high for exactly one clock, in the clock after the stop bit ends. `rx_word` changes only in that cycle and then holds until the next frame's `rx_done`.
- R9: A `load` that arrives while a frame is pending or in progress has no effect. A `load` in the cycle `rx_done` is high is accepted.
- R10: Changes on `data_in`, `nine_bit`, `cpha` and `last_pulse_en` after a frame's `load` do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | Single-cycle strobe at each bit boundary |
| os_tick | input | 1 | Single-cycle oversampling strobe, OS_RATE per bit |
| load | input | 1 | Frame request, accepted only when idle |
| data_in | input | DATA_W | Character to send |
| nine_bit | input | 1 | 1: DATA_W data bits, 0: DATA_W-1 data bits |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| last_pulse_en | input | 1 | Clock the last data bit when 1 |
| rxd | input | 1 | Serial data returned by the slave |
| txd | output | 1 | Serial frame output |
| sclk | output | 1 | Serial clock output |
| rx_word | output | DATA_W | Received word |
| rx_done | output | 1 | One-cycle strobe when a frame completes |

## Verification
The end of one frame and the request for the next can fall in the same cycle. The bench raises `load` in the very clock where `rx_done` is high. It then judges that the new frame is accepted, that its start bit appears at the next bit boundary, and that `rx_word` still shows the previous frame's value halfway through the new frame. A second overlap is a `load` together with flipped mode and data inputs in the middle of a running frame. The bench confirms that the reference slave still receives the original character in the original mode, and that no extra frame follows.

// File: rtl/usart_sync_pkg.sv
package usart_sync_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_START,
        PH_DATA,
        PH_STOP
    } frame_phase_e;

    typedef struct packed {
        logic nine;
        logic cpol;
        logic cpha;
        logic last_en;
    } line_mode_t;

endpackage

// File: rtl/usart_sync_phase.sv
module usart_sync_phase #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic os_tick,
    output logic mid_tick
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam int HALF  = OS_RATE / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } phase_state_t;

    phase_state_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (bit_tick) begin
            r_d.cnt = '0;
        end else if (os_tick && (r_q.cnt != CNT_W'(OS_RATE - 1))) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        mid_tick = os_tick && !bit_tick && (r_q.cnt == CNT_W'(HALF - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/usart_sync_seq.sv
module usart_sync_seq
    import usart_sync_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_tick,
    input  logic                      mid_tick,
    input  logic                      load,
    input  logic [DATA_W-1:0]         data_in,
    input  logic                      nine_bit,
    input  logic                      cpol,
    input  logic                      cpha,
    input  logic                      last_pulse_en,
    output logic                      txd,
    output logic                      sclk,
    output logic                      cap_en,
    output logic [$clog2(DATA_W)-1:0] cap_idx,
    output logic                      frame_start,
    output logic                      frame_end,
    output frame_phase_e              phase
);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        frame_phase_e      phase;
        line_mode_t        mode;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  idx;
        logic              act;
        logic              txd;
        logic              sclk;
    } seq_state_t;

    seq_state_t       r_q, r_d;
    logic [IDX_W-1:0] last_idx_d;
    logic [IDX_W-1:0] nxt_idx_d;
    logic             pulsed_d;

    always_comb begin
        r_d         = r_q;
        cap_en      = 1'b0;
        frame_start = 1'b0;
        frame_end   = 1'b0;
        last_idx_d  = r_q.mode.nine ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
        nxt_idx_d   = r_q.idx + 1'b1;
        pulsed_d    = (r_q.idx != last_idx_d) || r_q.mode.last_en;

        case (r_q.phase)
            PH_IDLE: begin
                if (load) begin
                    r_d.phase        = PH_WAIT;
                    r_d.mode.nine    = nine_bit;
                    r_d.mode.cpol    = cpol;
                    r_d.mode.cpha    = cpha;
                    r_d.mode.last_en = last_pulse_en;
                    r_d.data         = data_in;
                end
            end
            PH_WAIT: begin
                if (bit_tick) begin
                    r_d.phase   = PH_START;
                    r_d.txd     = 1'b0;
                    frame_start = 1'b1;
                end
            end
            PH_START: begin
                if (bit_tick) begin
                    r_d.phase = PH_DATA;
                    r_d.idx   = '0;
                    r_d.txd   = r_q.data[0];
                    r_d.act   = r_q.mode.cpha;
                end
            end
            PH_DATA: begin
                if (bit_tick) begin
                    if (r_q.idx == last_idx_d) begin
                        r_d.phase = PH_STOP;
                        r_d.txd   = 1'b1;
                        r_d.act   = 1'b0;
                    end else begin
                        r_d.idx  = nxt_idx_d;
                        r_d.data = r_q.data >> 1;
                        r_d.txd  = r_q.data[1];
                        r_d.act  = r_q.mode.cpha &&
                                   ((nxt_idx_d != last_idx_d) || r_q.mode.last_en);
                    end
                end else if (mid_tick && pulsed_d) begin
                    cap_en  = 1'b1;
                    r_d.act = !r_q.mode.cpha;
                end
            end
            PH_STOP: begin
                if (bit_tick) begin
                    r_d.phase = PH_IDLE;
                    frame_end = 1'b1;
                end
            end
            default: begin
                r_d.phase = PH_IDLE;
                r_d.txd   = 1'b1;
                r_d.act   = 1'b0;
            end
        endcase

        r_d.sclk = (r_d.phase == PH_IDLE) ? cpol : (r_d.mode.cpol ^ r_d.act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
            r_q.txd   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd     = r_q.txd;
    assign sclk    = r_q.sclk;
    assign cap_idx = r_q.idx;
    assign phase   = r_q.phase;

endmodule

// File: rtl/usart_sync_capture.sv
module usart_sync_capture #(
    parameter int DATA_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rxd,
    input  logic                      cap_en,
    input  logic [$clog2(DATA_W)-1:0] cap_idx,
    input  logic                      frame_start,
    input  logic                      frame_end,
    output logic [DATA_W-1:0]         rx_word,
    output logic                      rx_done
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] word;
        logic              done;
    } cap_state_t;

    cap_state_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (frame_start) begin
            r_d.sh = '0;
        end
        if (cap_en) begin
            r_d.sh[cap_idx] = rxd;
        end
        if (frame_end) begin
            r_d.word = r_d.sh;
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_word = r_q.word;
    assign rx_done = r_q.done;

endmodule

// File: rtl/usart_sync_tx.sv
module usart_sync_tx
    import usart_sync_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              os_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              nine_bit,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              last_pulse_en,
    input  logic              rxd,
    output logic              txd,
    output logic              sclk,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_done
);
    localparam int IDX_W = $clog2(DATA_W);

    logic             mid_tick;
    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;
    logic             frame_start;
    logic             frame_end;
    frame_phase_e     phase;

    usart_sync_phase #(.OS_RATE(OS_RATE)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .os_tick  (os_tick),
        .mid_tick (mid_tick)
    );

    usart_sync_seq #(.DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .mid_tick      (mid_tick),
        .load          (load),
        .data_in       (data_in),
        .nine_bit      (nine_bit),
        .cpol          (cpol),
        .cpha          (cpha),
        .last_pulse_en (last_pulse_en),
        .txd           (txd),
        .sclk          (sclk),
        .cap_en        (cap_en),
        .cap_idx       (cap_idx),
        .frame_start   (frame_start),
        .frame_end     (frame_end),
        .phase         (phase)
    );

    usart_sync_capture #(.DATA_W(DATA_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd         (rxd),
        .cap_en      (cap_en),
        .cap_idx     (cap_idx),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .rx_word     (rx_word),
        .rx_done     (rx_done)
    );

endmodule

// File: rtl/usart_sync_tx_checker.sv
module usart_sync_tx_checker
    import usart_sync_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd,
    input logic              sclk,
    input logic              rx_done,
    input logic [DATA_W-1:0] rx_word,
    input logic              cap_en,
    input frame_phase_e      phase
);
    logic quiet;
    assign quiet = (phase == PH_START) || (phase == PH_STOP);

    // R1: line rests high while idle or waiting for the bit boundary
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_IDLE) || (phase == PH_WAIT)) |-> txd);

    // R2: start bit low, stop bit high
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START) |-> !txd);
    a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STOP) |-> txd);

    // R4: no clock transition inside start or stop bit
    a_r4_quiet_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && $past(quiet)) |-> $stable(sclk));

    // R5: every sample point coincides with an sclk edge
    a_r5_sample_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !$stable(sclk));

    // R8: done is a single-cycle strobe, word only moves with it
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
    a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> $stable(rx_word));

endmodule

bind usart_sync_tx usart_sync_tx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd     (txd),
    .sclk    (sclk),
    .rx_done (rx_done),
    .rx_word (rx_word),
    .cap_en  (cap_en),
    .phase   (phase)
);

// File: tb/usart_sync_tx_test.sv
module usart_sync_tx_test;
    localparam int DW       = 9;
    localparam int OSR      = 16;
    localparam int OS_DIV   = 4;
    localparam int BIT_CLKS = OSR * OS_DIV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic          os_tick = 1'b0;
    logic          load = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          nine_bit = 1'b0;
    logic          cpol = 1'b0;
    logic          cpha = 1'b0;
    logic          last_pulse_en = 1'b1;
    logic          rxd = 1'b1;
    logic          txd;
    logic          sclk;
    logic [DW-1:0] rx_word;
    logic          rx_done;

    usart_sync_tx #(.DATA_W(DW), .OS_RATE(OSR)) uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .os_tick(os_tick),
        .load(load), .data_in(data_in), .nine_bit(nine_bit), .cpol(cpol),
        .cpha(cpha), .last_pulse_en(last_pulse_en), .rxd(rxd),
        .txd(txd), .sclk(sclk), .rx_word(rx_word), .rx_done(rx_done)
    );

    always #10 clk = ~clk;

    int  checks = 0;
    int  failures = 0;
    int  cyc = 0;
    bit  finished = 0;

    typedef struct {
        logic [DW-1:0] rx_exp;
        logic [DW-1:0] tx_exp;
        int            trans;
        int            nbits;
    } exp_t;
    exp_t exp_q[$];

    // reference slave state
    logic          s_cpol, s_cpha, s_prev, s_prev_txd;
    logic [DW-1:0] s_pat, s_word;
    int            s_trans, s_lead, s_trail, s_cap, s_fall;
    bit            s_armed = 0, s_started = 0;
    bit            last_ok = 0;
    logic [DW-1:0] last_rx = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // tick generator
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            os_tick  = (ph % OS_DIV) == 0;
            bit_tick = (ph == 0);
            ph = (ph + 1) % BIT_CLKS;
        end
    end

    // monitor: reference slave and scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            cyc++;
            if (s_armed) begin
                if (!s_started && s_prev_txd && !txd) begin
                    s_started = 1;
                    s_fall = cyc;
                end
                if (sclk !== s_prev) begin
                    s_trans++;
                    if (s_prev == s_cpol) begin
                        if (!s_cpha) begin
                            s_word[s_cap] = txd; s_cap++;
                        end else if (s_lead < DW) begin
                            rxd = s_pat[s_lead];
                        end
                        s_lead++;
                    end else begin
                        if (s_cpha) begin
                            s_word[s_cap] = txd; s_cap++;
                        end else if (s_trail + 1 < DW) begin
                            rxd = s_pat[s_trail + 1];
                        end
                        s_trail++;
                    end
                end
            end
            s_prev     = sclk;
            s_prev_txd = txd;
            if (rx_done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "unexpected rx_done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    last_ok = (rx_word == e.rx_exp) && (s_word == e.tx_exp) &&
                              (s_trans == e.trans);
                    last_rx = e.rx_exp;
                    chk(rx_word == e.rx_exp, "R7", "received word", rx_word, e.rx_exp);
                    chk(s_word == e.tx_exp, "R3 R5", "slave captured word", s_word, e.tx_exp);
                    chk(s_trans == e.trans, "R4 R6", "sclk transitions", s_trans, e.trans);
                    chk(s_started && (cyc - s_fall == (e.nbits + 2) * BIT_CLKS), "R2",
                        "start-to-done cycles", cyc - s_fall, (e.nbits + 2) * BIT_CLKS);
                    chk(txd && (sclk == s_cpol), "R1", "line idle at done",
                        {txd, sclk}, {1'b1, s_cpol});
                end
                s_armed = 0;
            end
        end
    end

    // driver: called just after a falling edge
    task automatic send(input logic [DW-1:0] d, input logic [DW-1:0] pat,
                        input bit n9, input bit cp, input bit ph, input bit le,
                        input bit disturb, input bit hold_chk);
        exp_t e;
        logic [DW-1:0] mask;
        int nb;
        nb   = n9 ? DW : DW - 1;
        mask = n9 ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
        e.rx_exp = pat & mask;
        e.tx_exp = d & mask;
        if (!le) begin
            e.rx_exp[nb-1] = 1'b0;
            e.tx_exp[nb-1] = 1'b0;
        end
        e.trans = 2 * (le ? nb : nb - 1);
        e.nbits = nb;
        nine_bit = n9; cpol = cp; cpha = ph; last_pulse_en = le;
        data_in = d; load = 1'b1;
        s_cpol = cp; s_cpha = ph; s_pat = pat; s_word = '0;
        s_trans = 0; s_lead = 0; s_trail = 0; s_cap = 0;
        s_started = 0; s_prev = cp; s_prev_txd = 1'b1; s_armed = 1;
        if (!ph) rxd = pat[0];
        exp_q.push_back(e);
        @(negedge clk); #1;
        load = 1'b0;
        if (hold_chk) begin
            repeat (4 * BIT_CLKS) @(negedge clk);
            // R8: previous word held while the next frame runs
            chk(rx_word == last_rx, "R8", "word held during next frame", rx_word, last_rx);
            #1;
        end
        if (disturb) begin
            repeat (5 * BIT_CLKS) @(negedge clk);
            #1;
            load = 1'b1; data_in = ~d; cpha = ~ph; nine_bit = ~n9; last_pulse_en = ~le;
            @(negedge clk); #1;
            load = 1'b0;
            repeat (BIT_CLKS) @(negedge clk);
            #1;
            data_in = d; cpha = ph; nine_bit = n9; last_pulse_en = le;
        end
        do @(negedge clk); while (!rx_done);
        #1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int bad;
        repeat (5) @(negedge clk);
        chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
        chk(rx_done == 1'b0, "R1", "rx_done in reset", rx_done, 0);
        chk(rx_word == '0, "R1", "rx_word in reset", rx_word, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R1", "sclk idle with cpol=0", sclk, 0);
        #1 cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R1", "sclk follows cpol=1", sclk, 1);
        #1 cpol = 1'b0;
        repeat (2) @(negedge clk);
        #1;

        // all modes, both widths, both last-pulse settings
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int l = 0; l < 2; l++) begin
                    logic [DW-1:0] d, p;
                    d = DW'(9'h0A5 ^ (m * 37 + w * 91 + l * 13));
                    p = DW'(9'h13C ^ (m * 53 + w * 29 + l * 71));
                    send(d, p, w[0], m[1], m[0], l[0], 0, 0);
                end
            end
        end

        // extreme data patterns
        send(9'h1FF, 9'h000, 1, 0, 1, 1, 0, 0);
        send(9'h000, 9'h1FF, 1, 1, 0, 1, 0, 0);
        send(9'h100, 9'h101, 0, 0, 0, 1, 0, 0);

        // R9 R10: load and mode changes mid-frame
        send(9'h0C3, 9'h05A, 0, 0, 1, 1, 1, 0);
        chk(last_ok, "R10", "frame unaffected by mid-frame input changes", last_ok, 1);
        bad = 0;
        for (int i = 0; i < 3 * BIT_CLKS; i++) begin
            @(negedge clk);
            if (!txd || rx_done) bad++;
        end
        chk(bad == 0, "R9", "no frame from load while busy", bad, 0);
        #1;

        // R9 R8: back-to-back, next load in the done cycle
        send(9'h1A6, 9'h0E1, 1, 1, 1, 0, 0, 0);
        send(9'h033, 9'h1CC, 1, 0, 0, 1, 0, 1);
        chk(last_ok, "R9", "frame loaded in done cycle", last_ok, 1);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "all expected frames completed", exp_q.size(), 0);
        finish_run();
    end

endmodule